// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Sequencer

This block steps one DMA channel through a ring of fixed-size descriptors in memory. Software sets the ring's start address and its size, then moves a tail pointer forward to hand descriptors to the engine. The engine keeps a current-descriptor pointer. While that pointer differs from the tail, the engine issues fetch requests for it on a valid/ready request port. After each fetch is acknowledged, the pointer moves to the next slot. When the pointer catches up with the tail, the engine parks in a suspended state. A later tail write that moves the tail away from the current pointer wakes it up.

Ownership comes only from the tail pointer: every slot from the current pointer up to one before the tail belongs to the engine, and there are no per-descriptor ownership flags. The pointer returns to the ring start after the last slot. Each channel has its own start and stop controls, so halting one instance has no effect on any other. Descriptor contents and data movement are handled elsewhere.

Top module: `desc_ring_seq`

## Requirements
- R1: After reset, state_o is 0 (stopped), cur_o is 0, req_valid_o is 0 and susp_o is 0.
- R2: state_o encodes 0 = stopped, 1 = running, 2 = suspended. A start_i pulse without stop_i sets the state to running and loads cur_o with the ring start address, on the next edge.
- R3: req_valid_o is high exactly when the state is running, no fetch is outstanding and cur_o differs from the tail. req_addr_o equals cur_o. An offered request holds its valid and address until req_ready_i is seen.
- R4: At most one fetch is outstanding. cur_o advances by DESC_BYTES (16) only on an ack_i that arrives while a fetch is outstanding. An ack_i at any other time has no effect.
- R5: The ring holds len+1 slots, where len is the value written through len_wr_i. After the acknowledgement of the slot at start + len*DESC_BYTES, cur_o returns to the ring start.
- R6: A running engine with no fetch outstanding and cur_o equal to the tail enters the suspended state on the next edge. On that same edge susp_o pulses high for exactly one cycle.
- R7: In the suspended state, a tail write whose value differs from cur_o returns the engine to running. A tail write equal to cur_o leaves it suspended.
- R8: stop_i sets the state to stopped on the next edge and drops any outstanding fetch. stop_i has priority over start_i.
- R9: A start-address write loads cur_o with the new address in any state, and abandons an outstanding fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_wr_i | input | 1 | Write strobe for the ring start address |
| base_i | input | AW | Ring start address |
| len_wr_i | input | 1 | Write strobe for the ring size |
| len_i | input | LW | Number of ring slots minus one |
| tail_wr_i | input | 1 | Write strobe for the tail pointer |
| tail_i | input | AW | Tail pointer: one past the last ready slot |
| start_i | input | 1 | Channel start pulse |
| stop_i | input | 1 | Channel stop pulse |
| req_valid_o | output | 1 | Descriptor fetch request valid |
| req_ready_i | input | 1 | Fetch request accepted |
| req_addr_o | output | AW | Address of the descriptor to fetch |
| ack_i | input | 1 | Fetch completion |
| cur_o | output | AW | Current descriptor pointer |
| state_o | output | 2 | 0 stopped, 1 running, 2 suspended |
| susp_o | output | 1 | One-cycle pulse on entry to suspend |

## Verification
The bench drives the engine with three request-port patterns: ready held high with a two-cycle ack, ready raised only every third cycle, and acks withheld. The first pattern checks the basic step and suspend sequence. The second shows whether a stalled request keeps its address. The third shows whether stray acks move the pointer. Tail writes are chosen to produce a short run, a run that wraps past the last slot, and a write equal to the current pointer. The last case separates a correct wake-up from a spurious one. Stop during an outstanding fetch, start together with stop, and start-address writes while running and while stopped cover the control priorities.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } ring_state_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int AW         = 32,
  parameter int LW         = 10,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_i,
  input  logic          len_wr_i,
  input  logic [LW-1:0] len_i,
  input  logic          start_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o
);
  localparam int SH = $clog2(DESC_BYTES);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q, cur_q, last_addr;
  logic [LW-1:0] len_q;
  logic          load, at_last;

  assign load      = base_wr_i | start_i;
  assign last_addr = base_q + (AW'(len_q) << SH);
  assign at_last   = (cur_q == last_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_wr_i) base_q <= base_i;
      if (len_wr_i)  len_q  <= len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cur_q <= '0;
    else if (base_wr_i) cur_q <= base_i;
    else if (start_i)   cur_q <= base_q;
    else if (adv_i)     cur_q <= at_last ? base_q : cur_q + STEP;
  end

  assign cur_o = cur_q;

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load && !at_last |=> cur_q == $past(cur_q) + STEP);
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load && at_last |=> cur_q == $past(base_q));
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic has_work_i,
  input  logic flush_i,
  input  logic ready_i,
  input  logic ack_i,
  output logic valid_o,
  output logic pend_o,
  output logic adv_o
);
  logic pend_q;

  assign valid_o = run_i & ~pend_q & has_work_i;
  assign adv_o   = ack_i & pend_q & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (flush_i)            pend_q <= 1'b0;
    else if (valid_o && ready_i) pend_q <= 1'b1;
    else if (adv_o)              pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !flush_i && run_i && has_work_i |=> pend_q == 1'b0);
  p_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !flush_i |=> pend_q);
endmodule

// File: rtl/ring_fsm.sv
module ring_fsm
  import ring_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        pend_i,
  input  logic        caught_up_i,
  input  logic        wake_i,
  output ring_state_e state_o,
  output logic        susp_o
);
  ring_state_e state_q, state_d;
  logic        go_susp;

  assign go_susp = (state_q == ST_RUN) && !pend_i && caught_up_i && !stop_i && !start_i;

  always_comb begin
    state_d = state_q;
    if (stop_i)                           state_d = ST_STOP;
    else if (start_i)                     state_d = ST_RUN;
    else if (go_susp)                     state_d = ST_SUSP;
    else if (state_q == ST_SUSP && wake_i) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOP;
      susp_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      susp_o  <= go_susp;
    end
  end

  assign state_o = state_q;

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == ST_STOP);
  p_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> state_q == ST_SUSP && $past(state_q) == ST_RUN);
  p_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'd3);
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
  import ring_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 10,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_i,
  input  logic          len_wr_i,
  input  logic [LW-1:0] len_i,
  input  logic          tail_wr_i,
  input  logic [AW-1:0] tail_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          ack_i,
  output logic [AW-1:0] cur_o,
  output logic [1:0]    state_o,
  output logic          susp_o
);
  logic [AW-1:0] tail_q, cur;
  logic          flush, pend, adv, run;
  ring_state_e   state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tail_q <= '0;
    else if (tail_wr_i) tail_q <= tail_i;
  end

  assign flush = stop_i | start_i | base_wr_i;
  assign run   = (state == ST_RUN);

  ring_ptr #(.AW(AW), .LW(LW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk_i, .rst_ni, .base_wr_i, .base_i, .len_wr_i, .len_i,
    .start_i(start_i & ~stop_i), .adv_i(adv), .cur_o(cur)
  );

  ring_fetch u_fetch (
    .clk_i, .rst_ni, .run_i(run), .has_work_i(cur != tail_q),
    .flush_i(flush), .ready_i(req_ready_i), .ack_i,
    .valid_o(req_valid_o), .pend_o(pend), .adv_o(adv)
  );

  ring_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .stop_i, .pend_i(pend),
    .caught_up_i(cur == tail_q), .wake_i(tail_wr_i && (tail_i != cur)),
    .state_o(state), .susp_o
  );

  assign req_addr_o = cur;
  assign cur_o      = cur;
  assign state_o    = state;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i && !flush && !tail_wr_i
      |=> req_valid_o && $stable(req_addr_o));
  p_susp_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_SUSP |-> !req_valid_o);
  p_base_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> cur_o == $past(base_i) && !pend);
endmodule

// File: tb/desc_ring_seq_tb.sv
module desc_ring_seq_tb;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int LW = 10;

  logic clk = 0, rst_n = 0;
  logic base_wr = 0, len_wr = 0, tail_wr = 0, start = 0, stop = 0;
  logic [AW-1:0] base_v = '0, tail_v = '0;
  logic [LW-1:0] len_v = '0;
  logic ready = 1, ack = 0;
  logic req_valid, susp;
  logic [AW-1:0] req_addr, cur;
  logic [1:0] state;

  int checks = 0, errors = 0, cyc = 0, ack_cnt = 0;
  bit auto_ack = 1, rdy_mode = 0, spur_ack = 0, done = 0;

  // reference model
  logic [AW-1:0] m_cur = 0, m_base = 0, m_tail = 0;
  int m_len = 0, m_state = 0;
  bit m_pend = 0, m_pulse = 0;

  always #(CLK_P/2) clk = ~clk;

  desc_ring_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_wr_i(base_wr), .base_i(base_v),
    .len_wr_i(len_wr), .len_i(len_v), .tail_wr_i(tail_wr), .tail_i(tail_v),
    .start_i(start), .stop_i(stop), .req_valid_o(req_valid), .req_ready_i(ready),
    .req_addr_o(req_addr), .ack_i(ack), .cur_o(cur), .state_o(state), .susp_o(susp)
  );

  function automatic bit m_valid();
    return m_state == 1 && !m_pend && m_cur != m_tail;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_base = 0; m_tail = 0; m_len = 0; m_state = 0; m_pend = 0; m_pulse = 0;
    end else begin
      bit fire, adv, flush, sgo;
      int ns;
      logic [AW-1:0] nc;
      fire  = m_valid() && ready;
      flush = stop || start || base_wr;
      adv   = ack && m_pend && !flush;
      sgo   = m_state == 1 && !m_pend && m_cur == m_tail && !stop && !start;
      ns = m_state;
      if (stop) ns = 0;
      else if (start) ns = 1;
      else if (sgo) ns = 2;
      else if (m_state == 2 && tail_wr && tail_v != m_cur) ns = 1;
      nc = m_cur;
      if (base_wr) nc = base_v;
      else if (start && !stop) nc = m_base;
      else if (adv) nc = (m_cur == m_base + AW'(m_len * 16)) ? m_base : m_cur + 16;
      if (flush) m_pend = 0; else if (fire) m_pend = 1; else if (adv) m_pend = 0;
      m_pulse = sgo; m_state = ns; m_cur = nc;
      if (base_wr) m_base = base_v;
      if (len_wr) m_len = int'(len_v);
      if (tail_wr) m_tail = tail_v;
    end
  end

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R2 state", AW'(state), AW'(m_state));
      chk("R4 cur", cur, m_cur);
      chk("R3 valid", AW'(req_valid), AW'(m_valid()));
      if (m_valid()) chk("R3 addr", req_addr, m_cur);
      chk("R6 pulse", AW'(susp), AW'(m_pulse));
    end
  end

  // request port stimulus
  always @(negedge clk) begin
    cyc++;
    ready <= rdy_mode ? (cyc % 3 == 0) : 1'b1;
    if (m_pend) ack_cnt++; else ack_cnt = 0;
    ack <= (auto_ack && m_pend && ack_cnt >= 2) || spur_ack;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_base(logic [AW-1:0] a);
    @(negedge clk); base_wr = 1; base_v = a; @(negedge clk); base_wr = 0;
  endtask
  task automatic wr_len(int l);
    @(negedge clk); len_wr = 1; len_v = LW'(l); @(negedge clk); len_wr = 0;
  endtask
  task automatic wr_tail(logic [AW-1:0] a);
    @(negedge clk); tail_wr = 1; tail_v = a; @(negedge clk); tail_wr = 0;
  endtask
  task automatic ctl(bit s, bit p);
    @(negedge clk); start = s; stop = p; @(negedge clk); start = 0; stop = 0;
  endtask
  task automatic wait_susp(int maxc);
    for (int i = 0; i < maxc && state != 2'd2; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 state", AW'(state), 0);
    chk("R1 cur", cur, 0);
    chk("R1 valid", AW'(req_valid), 0);
    chk("R1 pulse", AW'(susp), 0);
    rst_n = 1;
    tick(2);
    // short run: three slots of a four-slot ring
    wr_base(32'h1000); wr_len(3); wr_tail(32'h1030);
    ctl(1, 0);
    wait_susp(100); tick(1);
    chk("R6 suspended at tail", cur, 32'h1030);
    chk("R6 state", AW'(state), 2);
    // equal tail write keeps suspend
    wr_tail(32'h1030); tick(3);
    chk("R7 equal tail stays", AW'(state), 2);
    // wrap past last slot
    wr_tail(32'h1010);
    wait_susp(100); tick(1);
    chk("R5 wrapped to", cur, 32'h1010);
    // throttled ready
    rdy_mode = 1;
    wr_tail(32'h1000);
    wait_susp(200); tick(1);
    chk("R3 throttled run end", cur, 32'h1000);
    rdy_mode = 0;
    // stray ack while suspended
    @(negedge clk); spur_ack = 1; @(negedge clk); spur_ack = 0; tick(2);
    chk("R4 stray ack ignored", cur, 32'h1000);
    // stop while a fetch is outstanding
    auto_ack = 0;
    wr_tail(32'h1020); tick(3);
    ctl(0, 1);
    @(negedge clk); spur_ack = 1; @(negedge clk); spur_ack = 0; tick(2);
    chk("R8 stopped", AW'(state), 0);
    chk("R8 late ack ignored", cur, 32'h1000);
    auto_ack = 1;
    // start with stop together
    ctl(1, 1); tick(1);
    chk("R8 stop wins", AW'(state), 0);
    // start-address write while stopped and while running
    wr_base(32'h2000); tick(1);
    chk("R9 load stopped", cur, 32'h2000);
    wr_tail(32'h2040);
    ctl(1, 0); tick(5);
    wr_base(32'h3000); tick(1);
    chk("R9 load running", AW'(state), 1);
    tick(30);
    ctl(0, 1); tick(3);
    chk("R8 final stop", AW'(state), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule